// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits between a serial receiver and its receive FIFO on a multidrop RS-485 link that frames every character with nine bits. The ninth bit, which would otherwise carry parity, marks the character. When it is 1 the character is an address, and when it is 0 the character is data. For each received character the filter decides whether it reaches the FIFO. A kept character leaves on a write strobe one cycle later, together with its eight data bits and an address flag.

The filter has three receive behaviours. With both filter modes off, every character is kept. In normal multidrop mode, arming the filter holds back data until any address arrives, but only while the hold input is set. Automatic address mode keeps only an address that equals a programmed station value, together with the data that follows it. Software re-arms the filter with a one-cycle pulse, and the filter also re-arms when either mode is entered.

On the transmit side, the block produces the ninth bit from the parity controls. Stick parity turns that bit into a fixed address or data marker.

Top module: `nbit_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en` is 0.
- R2: With `md_en` and `aad_en` both 0, every character presented with `rx_valid` is written. `wr_data` equals `rx_char[7:0]`.
- R3: `wr_addr_flag` equals `rx_char[8]` of the written character. A value of 1 means address and 0 means data.
- R4: In normal multidrop mode (`md_en`=1, `aad_en`=0) with `rx_hold`=1, an armed filter discards data characters. Arming happens on entry to the mode or on a `rearm` pulse, and the filter stays armed until an address character arrives.
- R5: In normal multidrop mode, an address character is always written. The data characters after it are written until the filter is armed again.
- R6: In normal multidrop mode with `rx_hold`=0, data characters are written even when no address has been seen.
- R7: A one-cycle `rearm` pulse arms the filter. Data received after the pulse is discarded again under the conditions of R4.
- R8: In automatic address mode (`aad_en`=1), an address whose low 8 bits equal `match_addr` is written, and the data after it is written. Any other address is discarded and closes the filter, so its data is discarded too. Data received after entering the mode and before any matching address is discarded.
- R9: When `aad_en` and `md_en` are both 1, the automatic address rules of R8 apply.
- R10: With `tx_par_en`=1 and `tx_stick`=1, `tx_bit9` is 0 when `tx_even`=1 and 1 when `tx_even`=0.
- R11: With `tx_par_en`=1 and `tx_stick`=0, `tx_bit9` makes the nine bits have even parity when `tx_even`=1 and odd parity when `tx_even`=0. With `tx_par_en`=0, `tx_bit9` is 0.
- R12: A kept character produces exactly one `wr_en` pulse, in the cycle after its `rx_valid`. Back-to-back characters produce back-to-back writes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character; bit 8 is the address marker |
| md_en | input | 1 | Normal multidrop mode enable |
| aad_en | input | 1 | Automatic address mode enable |
| rx_hold | input | 1 | Discard data until an address in normal multidrop mode |
| rearm | input | 1 | One-cycle pulse that arms the filter |
| match_addr | input | 8 | Station address for automatic address mode |
| tx_data | input | 8 | Character being transmitted |
| tx_par_en | input | 1 | Transmit parity enable |
| tx_even | input | 1 | Even parity select |
| tx_stick | input | 1 | Stick parity select |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Data written to the FIFO |
| wr_addr_flag | output | 1 | Written character was an address |
| tx_bit9 | output | 1 | Ninth transmit bit |

## Verification
The assertions assume that `rx_valid` is 0 during reset. They also assume that the mode inputs, `rx_hold` and `rearm` never change in a cycle that carries a character, so that the judgement of each character depends on a settled arm state. The stimulus changes configuration only between characters, with at least one idle cycle after every mode change or rearm pulse. It sends characters either with idle gaps or as explicit back-to-back bursts in the pass-through mode.

// File: rtl/nbit_addr_filter.sv
module nbit_addr_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW:0]   rx_char,
  input  logic          md_en,
  input  logic          aad_en,
  input  logic          rx_hold,
  input  logic          rearm,
  input  logic [DW-1:0] match_addr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_par_en,
  input  logic          tx_even,
  input  logic          tx_stick,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_addr_flag,
  output logic          tx_bit9
);

  logic md_q, aad_q, gate_q;
  logic is_addr, addr_hit, md_act, arm, keep;

  assign is_addr  = rx_char[DW];
  assign addr_hit = (rx_char[DW-1:0] == match_addr);
  assign md_act   = md_en & ~aad_en;
  assign arm      = rearm | (md_act & ~md_q) | (aad_en & ~aad_q);

  always_comb begin
    if (aad_en)      keep = is_addr ? addr_hit : gate_q;
    else if (md_act) keep = is_addr | gate_q | ~rx_hold;
    else             keep = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q         <= 1'b0;
      aad_q        <= 1'b0;
      gate_q       <= 1'b0;
      wr_en        <= 1'b0;
      wr_data      <= '0;
      wr_addr_flag <= 1'b0;
    end else begin
      md_q  <= md_act;
      aad_q <= aad_en;
      if (arm)                     gate_q <= 1'b0;
      else if (rx_valid && is_addr) gate_q <= aad_en ? addr_hit : 1'b1;
      wr_en <= rx_valid & keep;
      if (rx_valid && keep) begin
        wr_data      <= rx_char[DW-1:0];
        wr_addr_flag <= is_addr;
      end
    end
  end

  assign tx_bit9 = !tx_par_en ? 1'b0 :
                   tx_stick   ? ~tx_even :
                   tx_even    ? ^tx_data : ~^tx_data;

  AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rx_valid)); // R12
  AST_FLAG_IS_BIT9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr_flag == $past(rx_char[DW]))); // R3
  AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !md_en && !aad_en) |=> (wr_en && wr_data == $past(rx_char[DW-1:0]))); // R2
  AST_MD_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && md_en && !aad_en && rx_char[DW]) |=> (wr_en && wr_addr_flag)); // R5
  AST_MD_OPEN_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && md_en && !aad_en && !rx_hold) |=> wr_en); // R6
  AST_AAD_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && aad_en && rx_char[DW] && rx_char[DW-1:0] != match_addr) |=> !wr_en); // R8
  AST_STICK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_par_en && tx_stick) |-> (tx_bit9 != tx_even)); // R10
  AST_NO_PARITY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_par_en |-> !tx_bit9); // R11

endmodule

// File: tb/test_nbit_addr_filter.sv
`timescale 1ns/1ps
module test_nbit_addr_filter;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0;
  logic [8:0] rx_char = '0;
  logic md_en = 0, aad_en = 0, rx_hold = 0, rearm = 0;
  logic [7:0] match_addr = '0, tx_data = '0;
  logic tx_par_en = 0, tx_even = 0, tx_stick = 0;
  logic wr_en, wr_addr_flag, tx_bit9;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  logic [8:0] expq[$];
  string reqq[$];

  always #4 clk = ~clk;

  nbit_addr_filter i_nbit_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .md_en(md_en), .aad_en(aad_en), .rx_hold(rx_hold), .rearm(rearm),
    .match_addr(match_addr), .tx_data(tx_data), .tx_par_en(tx_par_en),
    .tx_even(tx_even), .tx_stick(tx_stick), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr_flag(wr_addr_flag), .tx_bit9(tx_bit9));

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected write: actual %h expected none", {wr_addr_flag, wr_data});
      end else begin
        logic [8:0] e;
        string r;
        e = expq.pop_front();
        r = reqq.pop_front();
        if ({wr_addr_flag, wr_data} !== e) begin
          errors++;
          $display("FAIL %s write: actual %h expected %h", r, {wr_addr_flag, wr_data}, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] c, input bit kept, input string req);
    if (kept) begin
      expq.push_back(c);
      reqq.push_back(req);
    end
    rx_char = c;
    rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
    if (!kept) begin
      checks++;
      if (wr_en !== 1'b0) begin
        errors++;
        $display("FAIL %s discard of %h: actual wr_en %b expected 0", req, c, wr_en);
      end
    end
    @(negedge clk);
  endtask

  task automatic check_drained(input string req);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing writes: actual %0d pending expected 0", req, expq.size());
      expq.delete();
      reqq.delete();
    end
  endtask

  task automatic check_tx(input logic exp, input string req);
    #1;
    checks++;
    if (tx_bit9 !== exp) begin
      errors++;
      $display("FAIL %s tx bit9 for %h: actual %b expected %b", req, tx_data, tx_bit9, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    checks++;
    if (wr_en !== 1'b0) begin errors++; $display("FAIL R1 in reset: actual %b expected 0", wr_en); end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin errors++; $display("FAIL R1 after reset: actual %b expected 0", wr_en); end

    // R2 / R3 pass-through
    send(9'h055, 1, "R2");
    send(9'h1A3, 1, "R3");
    send(9'h0FF, 1, "R2");

    // R12 back-to-back burst
    for (int i = 0; i < 4; i++) begin
      logic [8:0] c;
      c = {i[0], 8'h20 + 8'(i)};
      expq.push_back(c);
      reqq.push_back("R12");
      rx_char = c;
      rx_valid = 1;
      @(negedge clk);
    end
    rx_valid = 0;
    idle(2);
    check_drained("R12");

    // R6 multidrop, no hold
    md_en = 1; rx_hold = 0; idle(1);
    send(9'h011, 1, "R6");
    send(9'h122, 1, "R6");
    send(9'h012, 1, "R6");

    // R4 / R5 multidrop with hold, armed by mode entry
    md_en = 0; idle(1);
    rx_hold = 1; md_en = 1; idle(1);
    send(9'h033, 0, "R4");
    send(9'h044, 0, "R4");
    send(9'h150, 1, "R5");
    send(9'h066, 1, "R5");
    send(9'h077, 1, "R5");

    // R7 software rearm
    rearm = 1; idle(1); rearm = 0; idle(1);
    send(9'h088, 0, "R7");
    send(9'h101, 1, "R7");
    send(9'h099, 1, "R7");

    // R8 / R9 automatic address mode (md_en still set)
    match_addr = 8'h42; aad_en = 1; idle(1);
    send(9'h010, 0, "R8");
    send(9'h143, 0, "R9");
    send(9'h011, 0, "R8");
    send(9'h142, 1, "R8");
    send(9'h012, 1, "R8");
    send(9'h17F, 0, "R8");
    send(9'h013, 0, "R8");
    send(9'h142, 1, "R9");
    send(9'h014, 1, "R9");
    idle(2);
    check_drained("R8");

    // R10 stick parity
    tx_par_en = 1; tx_stick = 1;
    for (int d = 0; d < 4; d++) begin
      tx_data = 8'(d * 37 + 5);
      tx_even = 1; check_tx(1'b0, "R10");
      tx_even = 0; check_tx(1'b1, "R10");
    end

    // R11 computed parity and disabled parity
    tx_stick = 0;
    for (int d = 0; d < 6; d++) begin
      tx_data = 8'(d * 53 + 1);
      tx_even = 1; check_tx(($countones(tx_data) % 2) == 1, "R11");
      tx_even = 0; check_tx(($countones(tx_data) % 2) == 0, "R11");
    end
    tx_par_en = 0; tx_data = 8'h07; tx_even = 0;
    check_tx(1'b0, "R11");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule